// File: doc/BRIEF.md
# Deep Sleep Sequencer with Low-Power Watchdog

This block moves a device into a deep sleep state and brings it back out with a reset-like restart. Software first sets an enable bit, then issues a one-cycle sleep command. While the device is asleep, a dedicated watchdog counts ticks from one of two slow oscillators: a low-power RC or a secondary crystal. The watchdog can end the sleep after a programmable timeout. An external interrupt, when it is enabled, can also end it.

If the watchdog is enabled and its selected oscillator is off when sleep begins, the block requests that oscillator itself. It holds the count until the oscillator reports ready, after a synchroniser of `SYNC_STAGES` flops.

Wake produces a one-cycle restart pulse and records the cause in sticky flags. It also sets a restart flag that a power-on sets as well. Together with a sticky sleep-status flag, software can tell three cases apart:
- status 0, restart flag 1: a plain power-on;
- status 1, restart flag 1: an exit from deep sleep;
- both flags 0: any other reset.

A hold output freezes pins and peripherals from sleep entry until software releases it. An active-low power-on reset clears everything.

Top module: `dslp_ctrl`

## Requirements
- R1: Deep sleep (`sleeping`=1) is entered only on a `sleep_cmd` cycle while `ds_en`=1. `ds_en` is set by a `ds_en_set` pulse. A command while `ds_en`=0 is ignored.
- R2: Entry sets `ds_status`. The flag stays set until a `ds_status_clr` pulse, and a wake does not clear it.
- R3: The watchdog counter restarts from zero on every entry. It counts only in deep sleep and only when `cfg_wdt_en`=1. A timeout occurs after 2^(6+2·`cfg_wdt_ps`) counted ticks. With a ready clock that ticks every cycle and `cfg_wdt_ps`=0, the wake occurs 64 cycles after the cycle that samples the command.
- R4: `cfg_wdt_src`=0 selects the RC oscillator and 1 selects the crystal. During deep sleep with the watchdog enabled, only the selected oscillator is requested. `lprc_req` is 0 while awake. `sosc_req` follows `sosc_keep_on` while awake and when the crystal is not needed.
- R5: Counting starts only once the selected oscillator's ready input has passed the `SYNC_STAGES` synchroniser. An oscillator that is already on at entry adds no delay.
- R6: `ext_wake` ends deep sleep only while `ext_wake_en`=1. Otherwise it is ignored.
- R7: A wake produces `wake_rst` high for exactly one cycle, in the cycle after the event is sampled. It sets `wake_by_wdt` and/or `wake_by_ext`, clears `ds_en` and sets `por_flag`.
- R8: `release_hold` is set on entry. It remains set after wake until a `release_clr` pulse while awake, and a `release_clr` during sleep is ignored.
- R9: `wake_by_wdt` and `wake_by_ext` stay set until a `wake_flags_clr` pulse.
- R10: `por_n`=0 clears sleep state, the watchdog, `ds_en`, `ds_status`, the wake flags and `release_hold`, and sets `por_flag`. `por_flag_clr` clears `por_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_wdt_en | input | 1 | Deep-sleep watchdog enable (static) |
| cfg_wdt_src | input | 1 | Watchdog clock: 0 RC, 1 crystal |
| cfg_wdt_ps | input | PS_W | Postscaler code |
| ds_en_set | input | 1 | Pulse: set the sleep enable bit |
| ds_status_clr | input | 1 | Pulse: clear sleep status flag |
| por_flag_clr | input | 1 | Pulse: clear restart flag |
| wake_flags_clr | input | 1 | Pulse: clear wake-cause flags |
| release_clr | input | 1 | Pulse: drop the hold |
| sleep_cmd | input | 1 | Sleep command strobe |
| ext_wake | input | 1 | External wake interrupt |
| ext_wake_en | input | 1 | External wake enable |
| sosc_keep_on | input | 1 | Software keeps crystal running |
| sosc_ready | input | 1 | Crystal ready (asynchronous) |
| lprc_ready | input | 1 | RC oscillator ready (asynchronous) |
| sosc_tick | input | 1 | Crystal tick strobe |
| lprc_tick | input | 1 | RC tick strobe |
| sosc_req | output | 1 | Crystal enable request |
| lprc_req | output | 1 | RC enable request |
| ds_en | output | 1 | Sleep enable bit |
| sleeping | output | 1 | In deep sleep |
| ds_status | output | 1 | Sticky sleep-entered flag |
| por_flag | output | 1 | Restart flag (power-on or wake) |
| wake_by_wdt | output | 1 | Wake cause: watchdog |
| wake_by_ext | output | 1 | Wake cause: external interrupt |
| release_hold | output | 1 | Pin and peripheral state frozen |
| wake_rst | output | 1 | One-cycle restart pulse |

## Verification
The hardest case to reach is a watchdog restart that follows an interrupted sleep. The counter has to be partly advanced when sleep ends another way, and the oscillator has to drop and come back up before the next entry.

The stimulus reaches it in stages:
- It enters sleep with the watchdog enabled and lets it count for a while.
- It wakes the block through the external interrupt.
- It re-enters at once, while the bench's oscillator model goes through its ready delay again.
- A scoreboard then expects the full timeout plus the delay, measured from the sampled command.

Oscillator start-up is modelled by a delay line on each request, so the added latency and the no-delay case of a pre-started crystal are both exact, predictable cycle counts.

// File: rtl/dslp_pkg.sv
package dslp_pkg;
   typedef enum logic [0:0] {
      ST_AWAKE = 1'b0,
      ST_SLEEP = 1'b1
   } dslp_state_e;

   localparam logic SRC_LPRC = 1'b0;
   localparam logic SRC_SOSC = 1'b1;
   localparam int   NUM_SRC  = 2;
endpackage

// File: rtl/dslp_src_sel.sv
module dslp_src_sel
   import dslp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleeping,
   input  logic wdt_en,
   input  logic src,
   input  logic keep_sosc,
   input  logic sosc_ready,
   input  logic lprc_ready,
   input  logic sosc_tick,
   input  logic lprc_tick,
   output logic sosc_req,
   output logic lprc_req,
   output logic sel_ready,
   output logic sel_tick
);
   initial assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
      else $error("SYNC_STAGES out of range");

   logic need;
   logic [NUM_SRC-1:0] raw_rdy;
   logic [NUM_SRC-1:0] syn_rdy;
   logic [NUM_SRC-1:0] tick_v;

   assign need     = sleeping & wdt_en;
   assign lprc_req = need & (src == SRC_LPRC);
   assign sosc_req = keep_sosc | (need & (src == SRC_SOSC));

   assign raw_rdy = {sosc_ready, lprc_ready};
   assign tick_v  = {sosc_tick, lprc_tick};

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (SYNC_STAGES == 0) begin : g_direct
         assign syn_rdy[g] = raw_rdy[g];
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= (sh << 1) | SYNC_STAGES'(raw_rdy[g]);
         end
         assign syn_rdy[g] = sh[SYNC_STAGES-1];

         // R5: a synchronised ready can only rise after the raw input was high
         p_ready_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(syn_rdy[g]) |-> $past(raw_rdy[g]));
      end
   end

   assign sel_ready = syn_rdy[src];
   assign sel_tick  = tick_v[src];

   // R4: the selected oscillator is requested whenever the watchdog needs it
   p_req_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && wdt_en) |-> (src == SRC_LPRC ? lprc_req : sosc_req));
   // R4: the RC oscillator is never requested while awake
   p_lprc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sleeping |-> !lprc_req);
endmodule

// File: rtl/dslp_wdt.sv
module dslp_wdt #(
   parameter int PS_W     = 4,
   parameter int BASE_EXP = 6,
   parameter int STEP     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enter,
   input  logic            count_en,
   input  logic [PS_W-1:0] ps,
   output logic            timeout
);
   localparam int MAX_EXP = BASE_EXP + STEP * ((1 << PS_W) - 1);
   localparam int CNT_W   = MAX_EXP + 1;

   initial assert (PS_W >= 1 && MAX_EXP <= 62 && BASE_EXP >= 1 && STEP >= 1)
      else $error("watchdog exponent parameters out of range");

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   always_comb begin
      lim = (CNT_W'(1) << (BASE_EXP + STEP * int'(ps))) - CNT_W'(1);
   end

   assign timeout = count_en & (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (enter)    cnt <= '0;
      else if (count_en) cnt <= cnt + CNT_W'(1);
   end

   // R3: each entry restarts the count from zero
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> (cnt == '0));
   // R3: a timeout never happens on a freshly cleared counter
   p_tmo_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (cnt != '0));
endmodule

// File: rtl/dslp_seq.sv
module dslp_seq
   import dslp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ds_en_set,
   input  logic status_clr,
   input  logic por_clr,
   input  logic flags_clr,
   input  logic release_clr,
   input  logic sleep_cmd,
   input  logic ext_wake,
   input  logic ext_wake_en,
   input  logic wdt_timeout,
   output logic enter,
   output logic sleeping,
   output logic ds_en,
   output logic ds_status,
   output logic por_flag,
   output logic wake_wdt,
   output logic wake_ext,
   output logic hold,
   output logic wake_rst
);
   dslp_state_e state;
   logic ext_ev, wake_any;

   assign sleeping = (state == ST_SLEEP);
   assign enter    = (state == ST_AWAKE) & sleep_cmd & ds_en;
   assign ext_ev   = sleeping & ext_wake & ext_wake_en;
   assign wake_any = ext_ev | (sleeping & wdt_timeout);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_AWAKE;
         ds_en     <= 1'b0;
         ds_status <= 1'b0;
         por_flag  <= 1'b1;
         wake_wdt  <= 1'b0;
         wake_ext  <= 1'b0;
         hold      <= 1'b0;
         wake_rst  <= 1'b0;
      end else begin
         wake_rst <= wake_any;

         if (enter)         state <= ST_SLEEP;
         else if (wake_any) state <= ST_AWAKE;

         if (wake_any)       ds_en <= 1'b0;
         else if (ds_en_set) ds_en <= 1'b1;

         if (enter)           ds_status <= 1'b1;
         else if (status_clr) ds_status <= 1'b0;

         if (wake_any)     por_flag <= 1'b1;
         else if (por_clr) por_flag <= 1'b0;

         if (sleeping && wdt_timeout) wake_wdt <= 1'b1;
         else if (flags_clr)          wake_wdt <= 1'b0;

         if (ext_ev)         wake_ext <= 1'b1;
         else if (flags_clr) wake_ext <= 1'b0;

         if (enter)                         hold <= 1'b1;
         else if (release_clr && !sleeping) hold <= 1'b0;
      end
   end

   // R1: without the enable bit the sequencer stays awake
   p_no_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping && !ds_en) |=> !sleeping);
   // R2: the status flag survives until software clears it
   p_status_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_status && !status_clr) |=> ds_status);
   // R7: the restart pulse lasts one cycle and leaves the enable bit clear
   p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_rst |=> !wake_rst);
   p_rst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_rst |-> (!ds_en && !sleeping && (wake_wdt || wake_ext) && por_flag));
   // R8: hold persists through sleep and until released
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && (sleeping || !release_clr)) |=> hold);
   // R9: wake-cause flags are sticky
   p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((wake_wdt || wake_ext) && !flags_clr) |=> (wake_wdt || wake_ext));
endmodule

// File: rtl/dslp_ctrl.sv
module dslp_ctrl #(
   parameter int PS_W        = 4,
   parameter int BASE_EXP    = 6,
   parameter int STEP        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            cfg_wdt_en,
   input  logic            cfg_wdt_src,
   input  logic [PS_W-1:0] cfg_wdt_ps,
   input  logic            ds_en_set,
   input  logic            ds_status_clr,
   input  logic            por_flag_clr,
   input  logic            wake_flags_clr,
   input  logic            release_clr,
   input  logic            sleep_cmd,
   input  logic            ext_wake,
   input  logic            ext_wake_en,
   input  logic            sosc_keep_on,
   input  logic            sosc_ready,
   input  logic            lprc_ready,
   input  logic            sosc_tick,
   input  logic            lprc_tick,
   output logic            sosc_req,
   output logic            lprc_req,
   output logic            ds_en,
   output logic            sleeping,
   output logic            ds_status,
   output logic            por_flag,
   output logic            wake_by_wdt,
   output logic            wake_by_ext,
   output logic            release_hold,
   output logic            wake_rst
);
   logic enter, sel_ready, sel_tick, count_en, timeout;

   assign count_en = sleeping & cfg_wdt_en & sel_ready & sel_tick;

   dslp_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk        (clk),
      .rst_n      (por_n),
      .sleeping   (sleeping),
      .wdt_en     (cfg_wdt_en),
      .src        (cfg_wdt_src),
      .keep_sosc  (sosc_keep_on),
      .sosc_ready (sosc_ready),
      .lprc_ready (lprc_ready),
      .sosc_tick  (sosc_tick),
      .lprc_tick  (lprc_tick),
      .sosc_req   (sosc_req),
      .lprc_req   (lprc_req),
      .sel_ready  (sel_ready),
      .sel_tick   (sel_tick)
   );

   dslp_wdt #(.PS_W(PS_W), .BASE_EXP(BASE_EXP), .STEP(STEP)) u_wdt (
      .clk      (clk),
      .rst_n    (por_n),
      .enter    (enter),
      .count_en (count_en),
      .ps       (cfg_wdt_ps),
      .timeout  (timeout)
   );

   dslp_seq u_seq (
      .clk         (clk),
      .rst_n       (por_n),
      .ds_en_set   (ds_en_set),
      .status_clr  (ds_status_clr),
      .por_clr     (por_flag_clr),
      .flags_clr   (wake_flags_clr),
      .release_clr (release_clr),
      .sleep_cmd   (sleep_cmd),
      .ext_wake    (ext_wake),
      .ext_wake_en (ext_wake_en),
      .wdt_timeout (timeout),
      .enter       (enter),
      .sleeping    (sleeping),
      .ds_en       (ds_en),
      .ds_status   (ds_status),
      .por_flag    (por_flag),
      .wake_wdt    (wake_by_wdt),
      .wake_ext    (wake_by_ext),
      .hold        (release_hold),
      .wake_rst    (wake_rst)
   );

   // R3: the watchdog never ends a sleep while it is disabled
   p_wdt_off_r3: assert property (@(posedge clk) disable iff (!por_n)
      (sleeping && !cfg_wdt_en && !(ext_wake && ext_wake_en)) |=> sleeping);
   // R6: a disabled external interrupt cannot end a sleep
   p_ext_masked_r6: assert property (@(posedge clk) disable iff (!por_n)
      (sleeping && !timeout && !ext_wake_en) |=> sleeping);
endmodule

// File: tb/dslp_ctrl_test.sv
module dslp_ctrl_test;
   localparam int OSC_DLY = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic cfg_wdt_en = 1'b0, cfg_wdt_src = 1'b0;
   logic [3:0] cfg_wdt_ps = 4'd0;
   logic ds_en_set = 1'b0, ds_status_clr = 1'b0, por_flag_clr = 1'b0;
   logic wake_flags_clr = 1'b0, release_clr = 1'b0, sleep_cmd = 1'b0;
   logic ext_wake = 1'b0, ext_wake_en = 1'b0, sosc_keep_on = 1'b0;
   logic sosc_ready, lprc_ready;
   logic sosc_req, lprc_req, ds_en, sleeping, ds_status, por_flag;
   logic wake_by_wdt, wake_by_ext, release_hold, wake_rst;

   logic [OSC_DLY-1:0] sosc_dl, lprc_dl;
   int cyc = 0;
   int cmd_cyc = 0;
   int checks = 0;
   int errors = 0;
   int wakes_seen = 0;

   typedef struct {
      bit w;
      bit e;
      int el;
   } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   always_ff @(posedge clk) cyc <= cyc + 1;

   // oscillator model: ready follows request after OSC_DLY clocks
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sosc_dl <= '0;
         lprc_dl <= '0;
      end else begin
         sosc_dl <= {sosc_dl[OSC_DLY-2:0], sosc_req};
         lprc_dl <= {lprc_dl[OSC_DLY-2:0], lprc_req};
      end
   end
   assign sosc_ready = sosc_dl[OSC_DLY-1];
   assign lprc_ready = lprc_dl[OSC_DLY-1];

   dslp_ctrl uut (
      .clk(clk), .por_n(por_n), .cfg_wdt_en(cfg_wdt_en), .cfg_wdt_src(cfg_wdt_src),
      .cfg_wdt_ps(cfg_wdt_ps), .ds_en_set(ds_en_set), .ds_status_clr(ds_status_clr),
      .por_flag_clr(por_flag_clr), .wake_flags_clr(wake_flags_clr),
      .release_clr(release_clr), .sleep_cmd(sleep_cmd), .ext_wake(ext_wake),
      .ext_wake_en(ext_wake_en), .sosc_keep_on(sosc_keep_on), .sosc_ready(sosc_ready),
      .lprc_ready(lprc_ready), .sosc_tick(1'b1), .lprc_tick(1'b1),
      .sosc_req(sosc_req), .lprc_req(lprc_req), .ds_en(ds_en), .sleeping(sleeping),
      .ds_status(ds_status), .por_flag(por_flag), .wake_by_wdt(wake_by_wdt),
      .wake_by_ext(wake_by_ext), .release_hold(release_hold), .wake_rst(wake_rst)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_clear_flags();
      wake_flags_clr = 1'b1; step(1); wake_flags_clr = 1'b0;
   endtask

   // driver: enable, then command; records the sampling cycle
   task automatic sleep_go();
      pulse_clear_flags();
      ds_en_set = 1'b1; step(1); ds_en_set = 1'b0;
      sleep_cmd = 1'b1; cmd_cyc = cyc + 1; step(1); sleep_cmd = 1'b0;
   endtask

   task automatic push_exp(input bit w, input bit e, input int el);
      exp_t it;
      it.w = w; it.e = e; it.el = el;
      exp_q.push_back(it);
   endtask

   task automatic wait_wake(input int target, input int maxc);
      for (int i = 0; i < maxc && wakes_seen < target; i++) step(1);
      chk("R7 wake observed", wakes_seen, target);
   endtask

   // monitor: compares each restart pulse with the scoreboard
   always @(negedge clk) begin
      if (por_n && wake_rst) begin
         wakes_seen++;
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R7 unexpected wake actual=1 expected=0 (cycle %0d)", cyc);
         end else begin
            exp_t it;
            it = exp_q.pop_front();
            chk("R3/R5 wake latency", cyc - cmd_cyc, it.el);
            chk("R7 wake_by_wdt", wake_by_wdt, it.w);
            chk("R7 wake_by_ext", wake_by_ext, it.e);
            chk("R7 ds_en cleared", ds_en, 0);
            chk("R7 por_flag set", por_flag, 1);
            chk("R8 hold at wake", release_hold, 1);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      // R10 reset state
      chk("R10 por_flag at reset", por_flag, 1);
      chk("R10 ds_status at reset", ds_status, 0);
      chk("R10 sleeping at reset", sleeping, 0);
      chk("R10 hold at reset", release_hold, 0);
      por_n = 1'b1;
      step(2);
      chk("R10 por_flag after reset", por_flag, 1);
      por_flag_clr = 1'b1; step(1); por_flag_clr = 1'b0;
      chk("R10 por_flag cleared", por_flag, 0);

      // R1: command without enable is ignored
      sleep_cmd = 1'b1; step(1); sleep_cmd = 1'b0; step(1);
      chk("R1 no entry without ds_en", sleeping, 0);
      chk("R2 status stays clear", ds_status, 0);

      // RC watchdog, ps 0: 64 ticks + oscillator + sync delay
      cfg_wdt_en = 1'b1; cfg_wdt_src = 1'b0; cfg_wdt_ps = 4'd0;
      push_exp(1, 0, 64 + OSC_DLY + 2);
      sleep_go();
      step(2);
      chk("R1 entered", sleeping, 1);
      chk("R2 status set", ds_status, 1);
      chk("R4 lprc requested", lprc_req, 1);
      chk("R4 sosc not requested", sosc_req, 0);
      release_clr = 1'b1; step(1); release_clr = 1'b0;
      chk("R8 release ignored in sleep", release_hold, 1);
      wait_wake(1, 200);
      step(5);
      chk("R8 hold persists", release_hold, 1);
      chk("R2 status survives wake", ds_status, 1);
      chk("R9 wdt flag sticky", wake_by_wdt, 1);
      chk("R4 lprc released", lprc_req, 0);
      release_clr = 1'b1; step(1); release_clr = 1'b0;
      chk("R8 hold released", release_hold, 0);
      ds_status_clr = 1'b1; step(1); ds_status_clr = 1'b0;
      chk("R2 status cleared", ds_status, 0);
      pulse_clear_flags();
      chk("R9 flags cleared", wake_by_wdt, 0);
      step(10);

      // R6: masked interrupt, watchdog off
      cfg_wdt_en = 1'b0; ext_wake_en = 1'b0;
      sleep_go();
      step(80);
      ext_wake = 1'b1; step(1); ext_wake = 1'b0; step(2);
      chk("R6 masked interrupt ignored", sleeping, 1);
      chk("R3 disabled watchdog idle", wake_by_wdt, 0);
      ext_wake_en = 1'b1;
      push_exp(0, 1, cyc + 1 - cmd_cyc);
      ext_wake = 1'b1; step(1); ext_wake = 1'b0;
      wait_wake(2, 20);
      step(2);
      chk("R9 ext flag sticky", wake_by_ext, 1);
      step(10);

      // R3 restart: interrupted count, then full timeout on re-entry (ps 1)
      cfg_wdt_en = 1'b1; cfg_wdt_ps = 4'd1;
      sleep_go();
      step(100);
      push_exp(0, 1, cyc + 1 - cmd_cyc);
      ext_wake = 1'b1; step(1); ext_wake = 1'b0;
      wait_wake(3, 20);
      step(12);
      ext_wake_en = 1'b0;
      push_exp(1, 0, 256 + OSC_DLY + 2);
      sleep_go();
      wait_wake(4, 400);
      step(10);

      // R5: crystal already running, no start-up delay
      cfg_wdt_ps = 4'd0; cfg_wdt_src = 1'b1; sosc_keep_on = 1'b1;
      step(10);
      push_exp(1, 0, 64);
      sleep_go();
      step(2);
      chk("R4 crystal requested", sosc_req, 1);
      chk("R4 rc not requested", lprc_req, 0);
      wait_wake(5, 200);
      sosc_keep_on = 1'b0;
      step(10);
      chk("R4 crystal released", sosc_req, 0);

      // R5: crystal off at entry, requested automatically
      push_exp(1, 0, 64 + OSC_DLY + 2);
      sleep_go();
      step(2);
      chk("R5 crystal auto request", sosc_req, 1);
      wait_wake(6, 200);
      step(10);

      // R10: power-on during sleep clears everything
      cfg_wdt_src = 1'b0; cfg_wdt_ps = 4'd3;
      por_flag_clr = 1'b1; step(1); por_flag_clr = 1'b0;
      sleep_go();
      step(20);
      por_n = 1'b0; step(2);
      chk("R10 sleep cleared", sleeping, 0);
      chk("R10 status cleared", ds_status, 0);
      chk("R10 por_flag set", por_flag, 1);
      chk("R10 hold cleared", release_hold, 0);
      chk("R10 enable cleared", ds_en, 0);
      chk("R10 rc request dropped", lprc_req, 0);
      por_n = 1'b1; step(20);
      chk("R10 no spurious wake", wakes_seen, 6);
      chk("R7 scoreboard drained", exp_q.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule